// File: doc/BRIEF.md
# Shared-Line Interrupt Aggregator

This block lets up to eight internal processes share a single host interrupt line on an expansion card. Each process raises a request input. The block brings each request into the system clock domain and records its rising edge in a pending register. The interrupt line is held active while any pending bit is set.

The host services the interrupt in two steps. First it reads the block's port and receives the pending bits on the upper byte of the data bus. It then writes a byte-wide mask to the same upper byte, where a 1 in bit k marks channel k as serviced. The bus strobes are asynchronous and active low. The block inverts them and re-times the write into the clock domain. Each serviced channel then receives a clear pulse lasting one clock, and the process must drop its request when it sees that pulse.

Top module: `irq_share_agg`

## Requirements
- R1: After reset the pending register is empty, `irq_o` is low, `clr_o` is all zero, and a host read returns 0x0000.
- R2: A rising edge on `req_i[k]`, taken after a two-flop synchroniser, sets pending bit k. A request that stays high does not set the bit again after it has been cleared.
- R3: `irq_o` is high exactly while at least one pending bit is set.
- R4: While `cs_i` is high and `bus_rd_n_i` is low, `bus_data_oe_o` is high. `bus_data_o[8+k]` then carries pending bit k, and `bus_data_o[7:0]` is zero. At any other time `bus_data_oe_o` is low and `bus_data_o` is zero.
- R5: A host write is a period in which `cs_i` is high and `bus_wr_n_i` is low, with `bus_data_i[15:8]` held stable for the whole period. After the strobe ends, `clr_o` equals the written mask for exactly one clock. No second pulse follows for the same write.
- R6: Pending bit k clears on the clock after its clear pulse. Pending bits whose mask bit is 0 are left unchanged, and a mask bit for an idle channel clears nothing.
- R7: A new rising edge of a request after its clear sets the pending bit again and produces a new rising edge on `irq_o`.
- R8: A write strobe while `cs_i` is low has no effect. A write of mask 0x00 produces no clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines from the internal processes, asynchronous |
| cs_i | input | 1 | Active-high chip select from the card's address decoder |
| bus_rd_n_i | input | 1 | Active-low host read strobe |
| bus_wr_n_i | input | 1 | Active-low host write strobe |
| bus_data_i | input | 16 | Host write data; only the upper byte is used |
| bus_data_o | output | 16 | Read data; the pending byte is on the upper lanes |
| bus_data_oe_o | output | 1 | High while the block drives the read data |
| irq_o | output | 1 | Shared interrupt line, active high |
| clr_o | output | N_SRC | Per-channel clear pulses, one clock long |

## Verification
The bench builds the block with N_SRC = 8 and SYNC_STAGES = 2. Channels 0 and 7 are both active, so the full upper byte and both of its end bits are exercised on the read path and the clear path. With two synchroniser stages the bench can predict exactly where each clear pulse lands. That makes the pulse-width and no-duplicate checks precise. It also lets the bench test a request that is still held high when its clear arrives, which must not set the pending bit again.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int BUS_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int HI_LSB   = 8;
    localparam int MAX_SRC  = 8;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pending_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t     st_d, st_q;
    logic [N-1:0] req_s;
    logic [N-1:0] rise;

    irq_sync #(.W(N), .STAGES(STAGES)) u_req_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(req_i),
        .sync_o (req_s)
    );

    always_comb begin
        rise      = req_s & ~st_q.prev;
        st_d.prev = req_s;
        // a fresh edge outranks a clear arriving in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.pend;
    assign irq_o     = |st_q.pend;

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pending_o & $past(rise)) == $past(rise)));

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~rise) != '0) |=> ((pending_o & $past(clr_i & ~rise)) == '0));

    assert_irq_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(rise) != '0));
endmodule

// File: rtl/irq_wr_pulse.sv
module irq_wr_pulse #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_async_i,
    input  logic [irq_agg_pkg::BYTE_W-1:0] data_i,
    output logic [N-1:0]                clr_o
);
    typedef struct packed {
        logic         prev;
        logic [N-1:0] mask;
        logic [N-1:0] clr;
    } wr_st_t;

    wr_st_t st_d, st_q;
    logic   wr_s;
    logic   start, fall;

    irq_sync #(.W(1), .STAGES(STAGES)) u_wr_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(wr_async_i),
        .sync_o (wr_s)
    );

    always_comb begin
        start     = wr_s & ~st_q.prev;
        fall      = st_q.prev & ~wr_s;
        st_d.prev = wr_s;
        // data is sampled once the strobe is seen, well after it settled
        st_d.mask = start ? data_i[N-1:0] : st_q.mask;
        st_d.clr  = fall ? st_q.mask : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_o = st_q.clr;

    assert_clear_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |=> (clr_o == '0));
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
    parameter int N_SRC       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SRC-1:0]                req_i,
    input  logic                            cs_i,
    input  logic                            bus_rd_n_i,
    input  logic                            bus_wr_n_i,
    input  logic [irq_agg_pkg::BUS_W-1:0]   bus_data_i,
    output logic [irq_agg_pkg::BUS_W-1:0]   bus_data_o,
    output logic                            bus_data_oe_o,
    output logic                            irq_o,
    output logic [N_SRC-1:0]                clr_o
);
    import irq_agg_pkg::*;

    localparam int HI_MSB = HI_LSB + BYTE_W - 1;

    logic [N_SRC-1:0]  pending;
    logic [BYTE_W-1:0] pend_byte;
    logic              rd_act, wr_act;
    logic [HI_LSB-1:0] unused_lo_lanes;

    // strobes are active low on the bus, active high inside
    assign rd_act          = cs_i & ~bus_rd_n_i;
    assign wr_act          = cs_i & ~bus_wr_n_i;
    assign unused_lo_lanes = bus_data_i[HI_LSB-1:0];

    irq_pending #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .clr_i    (clr_o),
        .pending_o(pending),
        .irq_o    (irq_o)
    );

    irq_wr_pulse #(.N(N_SRC), .STAGES(SYNC_STAGES)) u_wr_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_async_i(wr_act),
        .data_i    (bus_data_i[HI_MSB:HI_LSB]),
        .clr_o     (clr_o)
    );

    always_comb begin
        pend_byte              = '0;
        pend_byte[N_SRC-1:0]   = pending;
        bus_data_oe_o          = rd_act;
        bus_data_o             = '0;
        if (rd_act) bus_data_o[HI_MSB:HI_LSB] = pend_byte;
    end

    assert_irq_low_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && bus_data_o == '0) |-> !irq_o);
endmodule

// File: tb/irq_share_agg_bench.sv
module irq_share_agg_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic        cs = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        oe;
    logic        irq;
    logic [N-1:0] clr;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [7:0] exp_q[$];
    logic [N-1:0] clr_prev = '0;

    always #2 clk = ~clk;

    irq_share_agg #(.N_SRC(N), .SYNC_STAGES(2)) u_irq_share_agg (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cs_i(cs),
        .bus_rd_n_i(rd_n), .bus_wr_n_i(wr_n), .bus_data_i(wdata),
        .bus_data_o(rdata), .bus_data_oe_o(oe), .irq_o(irq), .clr_o(clr)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_read(output logic [15:0] d, output logic e);
        @(negedge clk);
        cs = 1'b1; rd_n = 1'b0;
        #1;
        d = rdata; e = oe;
        @(negedge clk);
        cs = 1'b0; rd_n = 1'b1;
    endtask

    // driver: pushes the pulse the write must cause
    task automatic host_write(input logic [7:0] mask, input bit sel);
        @(negedge clk);
        wdata = {mask, 8'h5A};
        cs = sel; wr_n = 1'b0;
        wait_clk(4);
        cs = 1'b0; wr_n = 1'b1;
        if (sel && mask != 8'h00) exp_q.push_back(mask);
        wait_clk(6);
    endtask

    // monitor: pops and compares each clear pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (clr != '0) begin
                checks++;
                pulses++;
                if (clr_prev != '0) begin
                    fails++;
                    $display("FAIL R5 pulse longer than one clock actual=0x%0h expected=0x0", clr);
                end else if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R8 unexpected clear actual=0x%0h expected=0x0", clr);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (clr != e) begin
                        fails++;
                        $display("FAIL R5 clear mask actual=0x%0h expected=0x%0h", clr, e);
                    end
                end
            end
            clr_prev <= clr;
        end
    end

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [15:0] d;
        logic        e;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);

        check(irq == 1'b0, "R1 irq after reset", 32'(irq), 0);
        check(clr == '0, "R1 clr after reset", 32'(clr), 0);
        host_read(d, e);
        check(d == 16'h0000 && e, "R1 read after reset", 32'(d), 0);

        // R4: strobe without select
        @(negedge clk); rd_n = 1'b0; #1;
        check(oe == 1'b0 && rdata == 16'h0, "R4 read without select", 32'({oe, rdata}), 0);
        @(negedge clk); rd_n = 1'b1;

        req[3] = 1'b1; wait_clk(5);
        check(irq == 1'b1, "R3 irq with one pending", 32'(irq), 1);
        host_read(d, e);
        check(d == 16'h0800, "R2 R4 single request on upper byte", 32'(d), 32'h0800);

        req[0] = 1'b1; req[7] = 1'b1; wait_clk(5);
        host_read(d, e);
        check(d == 16'h8900, "R2 three requests", 32'(d), 32'h8900);

        host_write(8'h08, 1'b1);
        req[3] = 1'b0;
        host_read(d, e);
        check(d == 16'h8100, "R6 subset cleared", 32'(d), 32'h8100);
        check(irq == 1'b1, "R3 irq still high", 32'(irq), 1);

        host_write(8'hFF, 1'b0);
        host_read(d, e);
        check(d == 16'h8100, "R8 write without select ignored", 32'(d), 32'h8100);

        host_write(8'h00, 1'b1);
        host_read(d, e);
        check(d == 16'h8100, "R8 zero mask", 32'(d), 32'h8100);

        // clear 0 and 7 while req[0] stays high
        host_write(8'h81, 1'b1);
        req[7] = 1'b0;
        host_read(d, e);
        check(d == 16'h0000, "R6 all cleared", 32'(d), 0);
        check(irq == 1'b0, "R3 irq low when empty", 32'(irq), 0);
        wait_clk(6);
        host_read(d, e);
        check(d == 16'h0000, "R2 held level does not re-set", 32'(d), 0);

        req[0] = 1'b0; wait_clk(4);
        check(irq == 1'b0, "R7 irq low before new edge", 32'(irq), 0);
        req[0] = 1'b1; wait_clk(5);
        check(irq == 1'b1, "R7 new edge raises irq", 32'(irq), 1);
        host_read(d, e);
        check(d == 16'h0100, "R7 new edge pending", 32'(d), 32'h0100);

        host_write(8'h02, 1'b1);
        host_read(d, e);
        check(d == 16'h0100, "R6 idle channel clear leaves others", 32'(d), 32'h0100);

        host_write(8'h01, 1'b1);
        req[0] = 1'b0;
        check(irq == 1'b0, "R3 irq low after last clear", 32'(irq), 0);
        wait_clk(4);
        check(exp_q.size() == 0, "R5 every expected pulse seen", 32'(exp_q.size()), 0);
        check(pulses == 4, "R5 R8 pulse count", 32'(pulses), 4);
        report();
    end
endmodule